// File: doc/BRIEF.md
# Predicated Branch and Call Unit

This block is the branch execution unit of a microcoded engine. Each issued 32-bit instruction word is decoded. Conditional jumps and conditional calls form their predicate from one bit of one condition register, and each opcode pair tests that bit either as set or as clear. A return needs no predicate. A taken operation does not redirect fetch at once. Exactly one further issued word, the delay slot, is allowed to complete first. Only then does the unit drive a single-cycle redirect carrying a byte address that is aligned to a 16-byte bundle.

A call saves the word address of the first word not yet issued. It writes that address into one of four return slots, which form a circular store. The store advances through a hidden pointer that wraps modulo four. Software reads the slots at memory offsets 0x500, 0x504, 0x508 and 0x50c, which correspond to slot indexes 0 to 3 on the read port. A return takes the most recently written slot and moves the pointer back. It then redirects to the bundle that holds the saved word.

Every branch-unit operation also writes one condition register. That write changes only the single bit owned by this unit. The other units' bits are passed through unchanged.

Top module: `pred_branch_unit`

## Requirements
- R1: Opcode byte (bits 31..24) 0xe0 is a jump taken when the selected flag is 1, and 0xe2 is a jump taken when it is 0. Any opcode outside the set 0xe0, 0xe2, 0xe4, 0xe6, 0xe8 causes no redirect and no condition-register write.
- R2: For jumps and calls, bits 5..3 select one of eight condition registers and bits 8..6 select the flag bit 0..7 inside it. Condition register r sits at cond_regs[16*r+15 : 16*r].
- R3: Bits 23..9 of a jump or call hold a bundle index. The redirect byte address equals that index times 16.
- R4: A taken operation raises redirect_valid for exactly one cycle. This happens in the cycle after the next issued word (the delay slot) is accepted, however many idle cycles come between. A word issued in the delay slot is not executed as a branch-unit operation.
- R5: Opcode 0xe4 is a call taken when the selected flag is 1, and 0xe6 is a call taken when it is 0. A taken call stores next_word into the slot named by the hidden pointer and then advances the pointer by one, modulo 4. A call that is not taken stores nothing and leaves the pointer where it is.
- R6: slot_idx 0..3 reads the slot at offset 0x500 + 4*slot_idx. After reset the pointer starts at slot 0, so the fifth taken call overwrites slot 0.
- R7: Opcode 0xe8 is a return and is always taken. Its bits 23..3 are ignored. It takes the most recently written slot, moves the pointer back by one modulo 4, and redirects to that slot's word address with the low two bits cleared, times 4.
- R8: Every executed branch-unit operation, taken or not, asserts creg_we for condition register bits 2..0. creg_wdata equals that register's current value with bit 13 set to 1, and every other bit is left unchanged.
- R9: After reset, redirect_valid is 0, nothing is pending, the pointer is at slot 0 and all four slots read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A word is issued this cycle |
| issue_word | input | 32 | The issued instruction word |
| cond_regs | input | 128 | Eight 16-bit condition registers, packed |
| next_word | input | 17 | Word address of the first word not yet issued |
| slot_idx | input | 2 | Return-slot read index |
| slot_word | output | 17 | Contents of the selected return slot |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr | output | 19 | Bundle-aligned byte address for fetch |
| creg_we | output | 1 | Condition-register write strobe |
| creg_idx | output | 3 | Condition register being written |
| creg_wdata | output | 16 | Full value to write |

## Verification
Each jump is tried with a background in which condition register r has only bit r set. A match between the register field and the bit field then gives 1 and any mismatch gives 0. Swapping either field, or testing the same flag under both opcodes of a pair, exposes a wrong field position and a missing or doubled negation. An opcode next to the valid ones shows that decoding is exact. The call and return sequence overruns the four slots, puts an untaken call between the calls, and then pops twice across the wrap, which separates correct pointer stepping from off-by-one errors. The delay-slot tests place idle cycles before the slot word, and also a taken jump inside the slot, to check both when the redirect fires and that the slot word is suppressed.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam logic [7:0] OP_JMP_SET  = 8'he0;
  localparam logic [7:0] OP_JMP_CLR  = 8'he2;
  localparam logic [7:0] OP_CALL_SET = 8'he4;
  localparam logic [7:0] OP_CALL_CLR = 8'he6;
  localparam logic [7:0] OP_RET      = 8'he8;

  localparam int OPC_LO  = 24;
  localparam int TGT_LO  = 9;
  localparam int FLAG_LO = 6;
  localparam int SRC_LO  = 3;
  localparam int DST_LO  = 0;
  localparam int FLAG_W  = 3;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_JUMP = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } bru_kind_e;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int NCREG = 8,
  parameter int CW    = 16,
  parameter int TGT_W = 15
) (
  input  logic [31:0]                instr,
  input  logic [NCREG*CW-1:0]        cond_regs,
  output bru_kind_e                  kind,
  output logic                       taken,
  output logic [TGT_W-1:0]           tgt_bundle,
  output logic [$clog2(NCREG)-1:0]   dst_idx
);
  localparam int CRI_W = $clog2(NCREG);

  logic [7:0]        opc;
  logic [CRI_W-1:0]  src_idx;
  logic [FLAG_W-1:0] flag_idx;
  logic [CW-1:0]     src_reg;
  logic              flag_bit;
  logic              want_set;

  assign opc        = instr[OPC_LO +: 8];
  assign src_idx    = instr[SRC_LO +: CRI_W];
  assign flag_idx   = instr[FLAG_LO +: FLAG_W];
  assign tgt_bundle = instr[TGT_LO +: TGT_W];
  assign dst_idx    = instr[DST_LO +: CRI_W];
  assign src_reg    = cond_regs[src_idx*CW +: CW];
  assign flag_bit   = src_reg[flag_idx];

  always_comb begin
    kind     = BK_NONE;
    want_set = 1'b1;
    case (opc)
      OP_JMP_SET:  begin kind = BK_JUMP; want_set = 1'b1; end
      OP_JMP_CLR:  begin kind = BK_JUMP; want_set = 1'b0; end
      OP_CALL_SET: begin kind = BK_CALL; want_set = 1'b1; end
      OP_CALL_CLR: begin kind = BK_CALL; want_set = 1'b0; end
      OP_RET:      begin kind = BK_RET;  want_set = 1'b1; end
      default:     begin kind = BK_NONE; want_set = 1'b1; end
    endcase
  end

  always_comb begin
    case (kind)
      BK_JUMP, BK_CALL: taken = (flag_bit == want_set);
      BK_RET:           taken = 1'b1;
      default:          taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_ret_stack.sv
module bru_ret_stack #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic [WORD_W-1:0]        push_word,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [WORD_W-1:0]        rd_word,
  output logic [WORD_W-1:0]        top_word
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] slot_q [DEPTH];
  logic [WORD_W-1:0] slot_d [DEPTH];
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [PTR_W-1:0]  top_ptr;

  assign top_ptr  = ptr_q - PTR_W'(1);
  assign top_word = slot_q[top_ptr];
  assign rd_word  = slot_q[rd_idx];

  always_comb begin
    ptr_d = ptr_q;
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (push) begin
      slot_d[ptr_q] = push_word;
      ptr_d         = ptr_q + PTR_W'(1);
    end else if (pop) begin
      ptr_d = top_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (push || pop) begin
      ptr_q <= ptr_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> slot_q[$past(ptr_q)] == $past(push_word)); // R5
  AST_POP_STEPS_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> ptr_q == $past(ptr_q) - PTR_W'(1)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/pred_branch_unit.sv
module pred_branch_unit
  import bru_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int NCREG   = 8,
  parameter int CW      = 16,
  parameter int OWN_BIT = 13,
  parameter int DEPTH   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     issue_valid,
  input  logic [31:0]              issue_word,
  input  logic [NCREG*CW-1:0]      cond_regs,
  input  logic [ADDR_W-3:0]        next_word,
  input  logic [$clog2(DEPTH)-1:0] slot_idx,
  output logic [ADDR_W-3:0]        slot_word,
  output logic                     redirect_valid,
  output logic [ADDR_W-1:0]        redirect_addr,
  output logic                     creg_we,
  output logic [$clog2(NCREG)-1:0] creg_idx,
  output logic [CW-1:0]            creg_wdata
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int TGT_W  = ADDR_W - 4;
  localparam int CRI_W  = $clog2(NCREG);
  localparam logic [CW-1:0]     OWN_MASK   = CW'(1) << OWN_BIT;
  localparam logic [ADDR_W-1:0] BUNDLE_LOW = ADDR_W'(15);

  bru_kind_e         kind;
  logic              taken;
  logic [TGT_W-1:0]  tgt_bundle;
  logic [CRI_W-1:0]  dst_idx;
  logic              op_live;
  logic              push, pop;
  logic [WORD_W-1:0] top_word;
  logic [ADDR_W-1:0] new_tgt;

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              redir_v_q, redir_v_d;
  logic [ADDR_W-1:0] redir_a_q, redir_a_d;

  bru_decode #(.NCREG(NCREG), .CW(CW), .TGT_W(TGT_W)) u_decode (
    .instr      (issue_word),
    .cond_regs  (cond_regs),
    .kind       (kind),
    .taken      (taken),
    .tgt_bundle (tgt_bundle),
    .dst_idx    (dst_idx)
  );

  assign op_live = issue_valid && !pend_q;
  assign push    = op_live && (kind == BK_CALL) && taken;
  assign pop     = op_live && (kind == BK_RET);

  bru_ret_stack #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_word (next_word),
    .rd_idx    (slot_idx),
    .rd_word   (slot_word),
    .top_word  (top_word)
  );

  always_comb begin
    if (kind == BK_RET) new_tgt = {top_word, 2'b00} & ~BUNDLE_LOW;
    else                new_tgt = {tgt_bundle, 4'b0000};
  end

  always_comb begin
    pend_d    = pend_q;
    tgt_d     = tgt_q;
    redir_v_d = 1'b0;
    redir_a_d = redir_a_q;
    if (pend_q && issue_valid) begin
      pend_d    = 1'b0;
      redir_v_d = 1'b1;
      redir_a_d = tgt_q;
    end else if (op_live && taken) begin
      pend_d = 1'b1;
      tgt_d  = new_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      tgt_q     <= '0;
      redir_v_q <= 1'b0;
      redir_a_q <= '0;
    end else begin
      pend_q    <= pend_d;
      redir_v_q <= redir_v_d;
      if (op_live && taken) tgt_q     <= tgt_d;
      if (redir_v_d)        redir_a_q <= redir_a_d;
    end
  end

  assign redirect_valid = redir_v_q;
  assign redirect_addr  = redir_a_q;
  assign creg_we        = op_live && (kind != BK_NONE);
  assign creg_idx       = dst_idx;
  assign creg_wdata     = cond_regs[dst_idx*CW +: CW] | OWN_MASK;

  AST_REDIR_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(issue_valid)); // R4
  AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid); // R4
  AST_SLOT_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && issue_valid) |-> (!creg_we && !push && !pop)); // R4
  AST_CREG_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    creg_we |-> (((creg_wdata ^ cond_regs[creg_idx*CW +: CW]) & ~OWN_MASK) == '0)
                && creg_wdata[OWN_BIT]); // R8
  AST_REDIR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_addr & BUNDLE_LOW) == '0); // R3
endmodule

// File: tb/pred_branch_unit_tb.sv
module pred_branch_unit_tb;
  localparam logic [31:0] NOP = 32'h4f00_0000;
  localparam int NV = 6;
  localparam logic [7:0]  V_OP   [NV] = '{8'he0, 8'he0, 8'he2, 8'he2, 8'he0, 8'he1};
  localparam logic [14:0] V_TGT  [NV] = '{15'h0001, 15'h0022, 15'h0333, 15'h1444, 15'h7fff, 15'h0055};
  localparam logic [2:0]  V_FLG  [NV] = '{3'd2, 3'd3, 3'd3, 3'd5, 3'd7, 3'd1};
  localparam logic [2:0]  V_REG  [NV] = '{3'd2, 3'd2, 3'd2, 3'd5, 3'd7, 3'd1};
  localparam logic        V_TAKE [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        V_UNIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  logic        clk, rst_n, issue_valid;
  logic [31:0] issue_word;
  logic [127:0] cond_regs;
  logic [16:0] next_word, slot_word;
  logic [1:0]  slot_idx;
  logic        redirect_valid, creg_we;
  logic [18:0] redirect_addr;
  logic [2:0]  creg_idx;
  logic [15:0] creg_wdata;

  int checks = 0, fails = 0;
  bit done = 0;

  pred_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
    .cond_regs(cond_regs), .next_word(next_word), .slot_idx(slot_idx),
    .slot_word(slot_word), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .creg_we(creg_we), .creg_idx(creg_idx), .creg_wdata(creg_wdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mk(input logic [7:0] op, input logic [14:0] tgt,
                                     input logic [2:0] flg, input logic [2:0] rg,
                                     input logic [2:0] dst);
    return {op, tgt, flg, rg, dst};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        g_v, g_we;
  logic [18:0] g_a;
  logic [2:0]  g_idx;
  logic [15:0] g_wd;

  task automatic run_op(input logic [31:0] w, input logic [16:0] nw);
    @(negedge clk);
    issue_valid = 1; issue_word = w; next_word = nw;
    #1; g_we = creg_we; g_idx = creg_idx; g_wd = creg_wdata;
    @(negedge clk);
    issue_word = NOP;
    @(negedge clk);
    issue_valid = 0;
    g_v = redirect_valid; g_a = redirect_addr;
  endtask

  task automatic chk_slot(input logic [1:0] idx, input logic [16:0] exp, input string req);
    slot_idx = idx; #1;
    chk(slot_word == exp, req, 32'(slot_word), 32'(exp));
  endtask

  localparam logic [16:0] CW0 = 17'h0_1235, CW1 = 17'h1_0004, CW2 = 17'h0_ff0b,
                          CW3 = 17'h1_abce, CW4 = 17'h0_0777;

  initial begin
    issue_valid = 0; issue_word = NOP; next_word = '0; slot_idx = 0;
    for (int r = 0; r < 8; r++) cond_regs[r*16 +: 16] = 16'h1 << r;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(redirect_valid == 0, "R9 redirect", 32'(redirect_valid), 0);
    for (int s = 0; s < 4; s++) chk_slot(2'(s), 17'h0, "R9 slot");
    rst_n = 1;

    // R1 R2 R3 R8: vector table of jumps
    for (int i = 0; i < NV; i++) begin
      run_op(mk(V_OP[i], V_TGT[i], V_FLG[i], V_REG[i], 3'(i)), 17'h0);
      chk(g_v == V_TAKE[i], "R1/R2 taken", 32'(g_v), 32'(V_TAKE[i]));
      if (V_TAKE[i]) chk(g_a == {V_TGT[i], 4'h0}, "R3 addr", 32'(g_a), 32'({V_TGT[i], 4'h0}));
      chk(g_we == V_UNIT[i], "R8 creg_we", 32'(g_we), 32'(V_UNIT[i]));
      if (V_UNIT[i]) begin
        chk(g_idx == 3'(i), "R8 creg_idx", 32'(g_idx), i);
        chk(g_wd == ((16'h1 << i) | 16'h2000), "R8 creg_wdata", 32'(g_wd),
            32'((16'h1 << i) | 16'h2000));
      end
    end

    // R4: idle cycles before the delay-slot word
    @(negedge clk); issue_valid = 1; issue_word = mk(8'he0, 15'h0123, 3'd4, 3'd4, 3'd0);
    @(negedge clk); issue_valid = 0;
    @(negedge clk); chk(redirect_valid == 0, "R4 no early redirect", 32'(redirect_valid), 0);
    @(negedge clk); chk(redirect_valid == 0, "R4 no early redirect", 32'(redirect_valid), 0);
    issue_valid = 1; issue_word = NOP;
    @(negedge clk); issue_valid = 0;
    chk(redirect_valid == 1, "R4 redirect after slot", 32'(redirect_valid), 1);
    chk(redirect_addr == 19'h01230, "R4 addr", 32'(redirect_addr), 32'h1230);
    @(negedge clk); chk(redirect_valid == 0, "R4 single pulse", 32'(redirect_valid), 0);

    // R4: taken jump inside the delay slot is not executed
    @(negedge clk); issue_valid = 1; issue_word = mk(8'he0, 15'h0010, 3'd3, 3'd3, 3'd1);
    @(negedge clk); issue_word = mk(8'he0, 15'h0020, 3'd6, 3'd6, 3'd4);
    #1; chk(creg_we == 0, "R4 slot word no write", 32'(creg_we), 0);
    @(negedge clk); issue_valid = 0;
    chk(redirect_addr == 19'h00100, "R4 first target kept", 32'(redirect_addr), 32'h100);
    @(negedge clk); issue_valid = 1; issue_word = NOP;
    @(negedge clk); issue_valid = 0;
    @(negedge clk); chk(redirect_valid == 0, "R4 slot jump ignored", 32'(redirect_valid), 0);

    // R5 R6: calls fill and wrap the slots
    run_op(mk(8'he4, 15'h0040, 3'd1, 3'd1, 3'd2), CW0);
    chk(g_v == 1 && g_a == 19'h00400, "R5 call redirect", 32'(g_a), 32'h400);
    run_op(mk(8'he6, 15'h0040, 3'd2, 3'd1, 3'd2), CW1);
    chk(g_v == 1, "R5 negated call taken", 32'(g_v), 1);
    run_op(mk(8'he4, 15'h0040, 3'd0, 3'd0, 3'd2), CW2);
    run_op(mk(8'he4, 15'h0040, 3'd5, 3'd5, 3'd2), CW3);
    chk_slot(0, CW0, "R6 slot0"); chk_slot(1, CW1, "R6 slot1");
    chk_slot(2, CW2, "R6 slot2"); chk_slot(3, CW3, "R6 slot3");
    run_op(mk(8'he6, 15'h0040, 3'd1, 3'd1, 3'd2), 17'h1_5555);
    chk(g_v == 0, "R5 untaken call", 32'(g_v), 0);
    chk(g_we == 1, "R8 untaken call writes", 32'(g_we), 1);
    for (int s = 0; s < 4; s++)
      chk_slot(2'(s), (s == 0) ? CW0 : (s == 1) ? CW1 : (s == 2) ? CW2 : CW3, "R5 untaken no store");
    run_op(mk(8'he4, 15'h0040, 3'd1, 3'd1, 3'd2), CW4);
    chk_slot(0, CW4, "R6 wrap overwrite"); chk_slot(1, CW1, "R6 slot1 kept");

    // R7: returns pop across the wrap, bits 23..3 ignored
    run_op(32'he8ff_fffb, 17'h0);
    chk(g_v == 1 && g_a == {CW4[16:2], 4'h0}, "R7 ret pop newest", 32'(g_a), 32'({CW4[16:2], 4'h0}));
    chk(g_we == 1 && g_idx == 3'd3, "R8 ret writes creg", 32'(g_idx), 3);
    run_op(32'he800_0005, 17'h0);
    chk(g_v == 1 && g_a == {CW3[16:2], 4'h0}, "R7 ret wraps back", 32'(g_a), 32'({CW3[16:2], 4'h0}));
    run_op(32'he812_3400, 17'h0);
    chk(g_a == {CW2[16:2], 4'h0}, "R7 third ret", 32'(g_a), 32'({CW2[16:2], 4'h0}));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule